// File: doc/BRIEF.md
# AXI Burst Write Engine

This block turns aligned user write requests into AXI write bursts. A request carries a start address, a beat count and a latency mode bit, and is accepted over a valid/ready handshake. Write data and byte strobes reach the block over their own valid/ready stream and are held in an internal FIFO. The timing of the data stream is independent of the timing of the request stream.

Each request is split into consecutive INCR bursts. A burst is cut at the configured beat limit and again at every 4 KB address page. In high latency mode a burst's address phase waits until the FIFO holds all of that burst's data that is not already claimed by earlier bursts. In low latency mode the address phase goes out at once, and the data phase waits for data as it arrives. The request port is free again as soon as the last address phase of a request has gone out. One completion pulse is reported per request after its last write response returns: done if every response was good, error otherwise.

Top module: `axi_wr_burst_engine`

## Requirements
- R1: A request of N beats is issued as consecutive bursts of at most MAX_BEATS beats each, whose beat counts add up to N. AWLEN equals the burst's beat count minus one. Each burst starts at the previous burst's address plus its beats times the bytes per word.
- R2: No burst crosses a 4096-byte address boundary. The lowest 12 address bits plus the burst's byte length never exceed 4096.
- R3: With the mode bit at 0 (high latency), a burst's AWVALID is raised only when the FIFO level, minus the beats of issued bursts not yet sent on W, is at least the burst's beat count. This is evaluated again for every burst of the request.
- R4: With the mode bit at 1 (low latency), address phases are issued without waiting for data. WVALID stays low while the FIFO is empty.
- R5: cmd_ready is high when idle and low from the accepted request until the cycle after the request's last AW handshake. It rises without waiting for the request's write data or responses.
- R6: cmd_done pulses for one cycle, one cycle after the B handshake of a request's last burst. No pulse follows the B handshake of any other burst.
- R7: If any burst of a request gets BRESP 2'b10 or 2'b11, cmd_err pulses in place of cmd_done. The next request starts with a clean error state. BRESP 2'b00 and 2'b01 count as good.
- R8: The number of AW handshakes not yet answered by a B handshake never exceeds MAX_OUTST.
- R9: W beats carry the pushed words and strobes in push order, whether the data came before, during or after the request. WVALID, WDATA and WLAST hold while WREADY is low.
- R10: AWSIZE equals log2 of the bytes per word, and AWBURST is 2'b01 (INCR) on every address phase.
- R11: WLAST is high exactly on the final beat of each burst.
- R12: While rst_n is low at a clock edge, all counters and queues are cleared, the FIFO is emptied, and AWVALID, WVALID, cmd_done and cmd_err go low. cmd_ready, wd_ready and m_bready are high after reset.
- R13: Once AWVALID is high, it stays high with AWADDR and AWLEN stable until AWREADY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_addr | input | ADDR_W | Word-aligned start address |
| cmd_beats | input | SIZE_W | Beats to write |
| cmd_lowlat | input | 1 | 1: low latency, 0: high latency |
| cmd_valid | input | 1 | Request valid |
| cmd_ready | output | 1 | Request ready |
| wd_data | input | DATA_W | Write data word |
| wd_strb | input | DATA_W/8 | Byte strobes of the word |
| wd_valid | input | 1 | Data valid |
| wd_ready | output | 1 | FIFO has room |
| cmd_done | output | 1 | Request completed without error |
| cmd_err | output | 1 | Request completed with an error response |
| m_awaddr | output | ADDR_W | AXI write address |
| m_awlen | output | 8 | AXI burst length minus one |
| m_awsize | output | 3 | AXI beat size code |
| m_awburst | output | 2 | AXI burst type |
| m_awvalid | output | 1 | AXI address valid |
| m_awready | input | 1 | AXI address ready |
| m_wdata | output | DATA_W | AXI write data |
| m_wstrb | output | DATA_W/8 | AXI write strobes |
| m_wlast | output | 1 | AXI final beat of burst |
| m_wvalid | output | 1 | AXI data valid |
| m_wready | input | 1 | AXI data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI response valid |
| m_bready | output | 1 | AXI response ready |

## Verification
On every cycle the assertions check the burst length cap, the 4 KB page rule, the outstanding-transaction bound, and the holding of AW and W while stalled. They also check that completion pulses only follow the final burst's response, that done and error never coincide, and that the request port reopens only after the last address phase. The bench scenarios show what depends on sequences: the exact burst addresses and lengths a request is split into, and the way high latency holds back each burst until its data is buffered. They also show low latency issuing ahead of data, in-order data with strobes pushed before or after the request, and an error response turning exactly one completion into an error.

// File: rtl/awb_pkg.sv
package awb_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam int unsigned PAGE_BYTES = 4096;

  typedef enum logic [1:0] {SP_IDLE, SP_PLAN, SP_ADDR} split_state_e;

  // Beats of the next burst: limited by what is left, by the cap and by the page end.
  function automatic int unsigned burst_beats(input int unsigned remaining,
                                              input int unsigned addr_lo12,
                                              input int unsigned max_beats,
                                              input int unsigned bytes_per_beat);
    int unsigned to_page;
    int unsigned n;
    to_page = (PAGE_BYTES - addr_lo12) / bytes_per_beat;
    n = remaining;
    if (n > max_beats) n = max_beats;
    if (n > to_page)   n = to_page;
    return n;
  endfunction

  // Good responses are OKAY and EXOKAY; the upper bit marks a slave or decode error.
  function automatic logic resp_is_error(input logic [1:0] resp);
    return (resp == 2'b10) || (resp == 2'b11);
  endfunction

endpackage

// File: rtl/awb_fifo.sv
module awb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [W-1:0]     out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push, pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/awb_split.sv
module awb_split #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int MAX_BEATS = 16,
  parameter int MAX_OUTST = 4,
  parameter int BYTES     = 4,
  parameter int LEN_W     = 5,
  parameter int FCNT_W    = 6,
  parameter int PEND_W    = 7,
  parameter int OUT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_beats,
  input  logic              cmd_lowlat,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [FCNT_W-1:0] fifo_level,
  input  logic [PEND_W-1:0] w_pending,
  input  logic [OUT_W-1:0]  outst,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic              aw_fire,
  output logic [LEN_W-1:0]  aw_beats,
  output logic              aw_last
);
  import awb_pkg::*;

  split_state_e      state;
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] remaining;
  logic              lowlat_q;
  logic [LEN_W-1:0]  next_beats;
  logic              data_ok, slot_ok;

  assign cmd_ready  = (state == SP_IDLE);
  assign next_beats = LEN_W'(burst_beats(32'(remaining), 32'(cur_addr[11:0]),
                                         MAX_BEATS, BYTES));
  // High latency: buffered words not claimed by issued bursts must cover this burst.
  assign data_ok    = lowlat_q ||
                      (32'(fifo_level) >= 32'(w_pending) + 32'(next_beats));
  assign slot_ok    = 32'(outst) < MAX_OUTST;
  assign aw_fire    = aw_valid && aw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SP_IDLE;
      cur_addr  <= '0;
      remaining <= '0;
      lowlat_q  <= 1'b0;
      aw_valid  <= 1'b0;
      aw_addr   <= '0;
      aw_len    <= '0;
      aw_beats  <= '0;
      aw_last   <= 1'b0;
    end else begin
      case (state)
        SP_IDLE: begin
          if (cmd_valid && (cmd_beats != '0)) begin
            cur_addr  <= cmd_addr;
            remaining <= cmd_beats;
            lowlat_q  <= cmd_lowlat;
            state     <= SP_PLAN;
          end
        end
        SP_PLAN: begin
          if (data_ok && slot_ok) begin
            aw_valid <= 1'b1;
            aw_addr  <= cur_addr;
            aw_len   <= 8'(next_beats - 1'b1);
            aw_beats <= next_beats;
            aw_last  <= (32'(next_beats) == 32'(remaining));
            state    <= SP_ADDR;
          end
        end
        SP_ADDR: begin
          if (aw_ready) begin
            aw_valid  <= 1'b0;
            cur_addr  <= cur_addr + ADDR_W'(32'(aw_beats) * BYTES);
            remaining <= remaining - SIZE_W'(aw_beats);
            state     <= aw_last ? SP_IDLE : SP_PLAN;
          end
        end
        default: state <= SP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/awb_wchan.sv
module awb_wchan #(
  parameter int DATA_W     = 32,
  parameter int STRB_W     = 4,
  parameter int FIFO_DEPTH = 32,
  parameter int MAX_OUTST  = 4,
  parameter int LEN_W      = 5,
  parameter int FCNT_W     = 6,
  parameter int PEND_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wd_data,
  input  logic [STRB_W-1:0] wd_strb,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic              aw_fire,
  input  logic [LEN_W-1:0]  aw_beats,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic [FCNT_W-1:0] fifo_level,
  output logic [PEND_W-1:0] w_pending,
  output logic              lq_space
);

  localparam int LQ_CNT_W = $clog2(MAX_OUTST + 1);

  logic                     df_valid, lq_valid, w_fire;
  logic [LEN_W-1:0]         head_beats, beat_cnt;
  logic [LQ_CNT_W-1:0]      lq_count;

  awb_fifo #(.W(DATA_W + STRB_W), .DEPTH(FIFO_DEPTH)) u_data_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_data({wd_strb, wd_data}), .in_valid(wd_valid), .in_ready(wd_ready),
    .out_data({m_wstrb, m_wdata}), .out_valid(df_valid), .out_ready(w_fire),
    .count(fifo_level)
  );

  // One entry per issued burst: its beat count, consumed when its last beat leaves.
  awb_fifo #(.W(LEN_W), .DEPTH(MAX_OUTST)) u_len_queue (
    .clk(clk), .rst_n(rst_n),
    .in_data(aw_beats), .in_valid(aw_fire), .in_ready(lq_space),
    .out_data(head_beats), .out_valid(lq_valid), .out_ready(w_fire && m_wlast),
    .count(lq_count)
  );

  assign m_wvalid = lq_valid && df_valid && (lq_count != '0);
  assign m_wlast  = lq_valid && (beat_cnt == head_beats - 1'b1);
  assign w_fire   = m_wvalid && m_wready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt  <= '0;
      w_pending <= '0;
    end else begin
      if (w_fire) beat_cnt <= m_wlast ? '0 : beat_cnt + 1'b1;
      case ({aw_fire, w_fire})
        2'b10:   w_pending <= w_pending + PEND_W'(aw_beats);
        2'b01:   w_pending <= w_pending - 1'b1;
        2'b11:   w_pending <= w_pending + PEND_W'(aw_beats) - 1'b1;
        default: w_pending <= w_pending;
      endcase
    end
  end

endmodule

// File: rtl/awb_resp.sv
module awb_resp #(
  parameter int MAX_OUTST = 4,
  parameter int OUT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_fire,
  input  logic             aw_last,
  input  logic [1:0]       m_bresp,
  input  logic             m_bvalid,
  output logic             m_bready,
  output logic [OUT_W-1:0] outst,
  output logic             b_fire,
  output logic             b_last,
  output logic             rq_space,
  output logic             rq_valid,
  output logic             cmd_done,
  output logic             cmd_err
);
  import awb_pkg::*;

  logic [OUT_W-1:0] rq_count;
  logic             err_acc, b_bad;

  // Marks which outstanding burst closes its request.
  awb_fifo #(.W(1), .DEPTH(MAX_OUTST)) u_last_queue (
    .clk(clk), .rst_n(rst_n),
    .in_data(aw_last), .in_valid(aw_fire), .in_ready(rq_space),
    .out_data(b_last), .out_valid(rq_valid), .out_ready(b_fire),
    .count(rq_count)
  );

  assign m_bready = 1'b1;
  assign b_fire   = m_bvalid && m_bready;
  assign b_bad    = resp_is_error(m_bresp);
  assign outst    = rq_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_acc  <= 1'b0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      if (b_fire) begin
        if (b_last) begin
          cmd_done <= !(err_acc || b_bad);
          cmd_err  <= err_acc || b_bad;
          err_acc  <= 1'b0;
        end else begin
          err_acc  <= err_acc || b_bad;
        end
      end
    end
  end

endmodule

// File: rtl/axi_wr_burst_engine.sv
module axi_wr_burst_engine #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int MAX_BEATS  = 16,
  parameter int MAX_OUTST  = 4,
  parameter int FIFO_DEPTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [SIZE_W-1:0]     cmd_beats,
  input  logic                  cmd_lowlat,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [DATA_W-1:0]     wd_data,
  input  logic [DATA_W/8-1:0]   wd_strb,
  input  logic                  wd_valid,
  output logic                  wd_ready,
  output logic                  cmd_done,
  output logic                  cmd_err,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic [2:0]            m_awsize,
  output logic [1:0]            m_awburst,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready
);

  localparam int BYTES     = DATA_W / 8;
  localparam int SIZE_CODE = $clog2(BYTES);
  localparam int LEN_W     = $clog2(MAX_BEATS + 1);
  localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1);
  localparam int PEND_W    = $clog2(MAX_OUTST * MAX_BEATS + 1);
  localparam int OUT_W     = $clog2(MAX_OUTST + 1);

  // Internal events, named for the checker.
  logic              aw_fire, aw_last, b_fire, b_last;
  logic              lq_space, rq_space, rq_valid;
  logic [LEN_W-1:0]  aw_beats;
  logic [FCNT_W-1:0] fifo_level;
  logic [PEND_W-1:0] w_pending;
  logic [OUT_W-1:0]  outst;

  assign m_awsize  = 3'(SIZE_CODE);
  assign m_awburst = awb_pkg::BURST_INCR;

  awb_split #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_BEATS(MAX_BEATS), .MAX_OUTST(MAX_OUTST),
    .BYTES(BYTES), .LEN_W(LEN_W), .FCNT_W(FCNT_W), .PEND_W(PEND_W), .OUT_W(OUT_W)
  ) u_split (
    .clk(clk), .rst_n(rst_n),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .cmd_lowlat(cmd_lowlat),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .fifo_level(fifo_level), .w_pending(w_pending), .outst(outst),
    .aw_addr(m_awaddr), .aw_len(m_awlen), .aw_valid(m_awvalid), .aw_ready(m_awready),
    .aw_fire(aw_fire), .aw_beats(aw_beats), .aw_last(aw_last)
  );

  awb_wchan #(
    .DATA_W(DATA_W), .STRB_W(BYTES), .FIFO_DEPTH(FIFO_DEPTH), .MAX_OUTST(MAX_OUTST),
    .LEN_W(LEN_W), .FCNT_W(FCNT_W), .PEND_W(PEND_W)
  ) u_wchan (
    .clk(clk), .rst_n(rst_n),
    .wd_data(wd_data), .wd_strb(wd_strb), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .aw_fire(aw_fire), .aw_beats(aw_beats),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .fifo_level(fifo_level), .w_pending(w_pending), .lq_space(lq_space)
  );

  awb_resp #(.MAX_OUTST(MAX_OUTST), .OUT_W(OUT_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .aw_fire(aw_fire), .aw_last(aw_last),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .outst(outst), .b_fire(b_fire), .b_last(b_last),
    .rq_space(rq_space), .rq_valid(rq_valid),
    .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

endmodule

// File: rtl/awb_checker.sv
module awb_checker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 16,
  parameter int MAX_OUTST = 4,
  parameter int OUT_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_done,
  input logic              cmd_err,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_wlast,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              aw_fire,
  input logic              aw_last,
  input logic              b_fire,
  input logic              b_last,
  input logic              lq_space,
  input logic              rq_space,
  input logic              rq_valid,
  input logic [OUT_W-1:0]  outst
);

  localparam int BYTES = DATA_W / 8;

  p_len_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (32'(m_awlen) < MAX_BEATS));

  p_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (32'(m_awaddr[11:0]) + (32'(m_awlen) + 32'd1) * 32'(BYTES) <= 32'd4096));

  p_ready_after_last_aw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> $past(aw_fire && aw_last));

  p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done || cmd_err) |-> $past(b_fire && b_last));

  p_b_expected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_fire |-> rq_valid);

  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && cmd_err));

  p_outst_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outst) <= MAX_OUTST);

  p_aw_queues_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |-> (lq_space && rq_space));

  p_w_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

  p_aw_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));

endmodule

bind axi_wr_burst_engine awb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS),
  .MAX_OUTST(MAX_OUTST), .OUT_W(OUT_W)
) u_awb_checker (
  .clk(clk), .rst_n(rst_n),
  .cmd_ready(cmd_ready), .cmd_done(cmd_done), .cmd_err(cmd_err),
  .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wdata(m_wdata), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
  .aw_fire(aw_fire), .aw_last(aw_last), .b_fire(b_fire), .b_last(b_last),
  .lq_space(lq_space), .rq_space(rq_space), .rq_valid(rq_valid), .outst(outst)
);

// File: tb/test_axi_wr_burst_engine.sv
module test_axi_wr_burst_engine;

  localparam int ADDR_W = 32, DATA_W = 32, SIZE_W = 12;
  localparam int MAX_BEATS = 4, MAX_OUTST = 2, FIFO_DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [SIZE_W-1:0] cmd_beats = '0;
  logic cmd_lowlat = 1'b0, cmd_valid = 1'b0, cmd_ready;
  logic [DATA_W-1:0] wd_data = '0;
  logic [3:0] wd_strb = '0;
  logic wd_valid = 1'b0, wd_ready, cmd_done, cmd_err;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic m_awvalid, m_wlast, m_wvalid, m_bready;
  logic aw_rdy_en = 1'b1, w_stall = 1'b0, tog = 1'b0;
  logic m_awready, m_wready;
  logic [DATA_W-1:0] m_wdata;
  logic [3:0] m_wstrb;
  logic [1:0] m_bresp = 2'b00;
  logic m_bvalid = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) tog <= ~tog;
  assign m_awready = aw_rdy_en;
  assign m_wready  = w_stall ? tog : 1'b1;

  axi_wr_burst_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .MAX_BEATS(MAX_BEATS), .MAX_OUTST(MAX_OUTST), .FIFO_DEPTH(FIFO_DEPTH)
  ) i_axi_wr_burst_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .cmd_lowlat(cmd_lowlat),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .wd_data(wd_data), .wd_strb(wd_strb), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .cmd_done(cmd_done), .cmd_err(cmd_err),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
  );

  int n_checks = 0, n_fail = 0;
  int aw_n = 0, w_n = 0, w_beat = 0, w_burst = 0, wl_done = 0;
  int b_sent = 0, b_seen = 0, done_cnt = 0, err_cnt = 0, push_idx = 0, peak = 0;
  int err_idx = -1;
  bit finished = 1'b0;
  logic [ADDR_W-1:0] aw_addr_log [64];
  logic [7:0]        aw_len_log  [64];

  function automatic logic [31:0] pat_data(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'd7;
  endfunction
  function automatic logic [3:0] pat_strb(input int i);
    return 4'(i * 3 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Bus monitor, sampling away from the active edge.
  always @(negedge clk) if (rst_n) begin
    if (m_awvalid && m_awready) begin
      aw_addr_log[aw_n % 64] = m_awaddr;
      aw_len_log[aw_n % 64]  = m_awlen;
      chk(m_awsize == 3'd2 && m_awburst == 2'b01, "R10 awsize/awburst",
          {59'd0, m_awsize, m_awburst}, {59'd0, 3'd2, 2'b01});
      aw_n++;
    end
    if (m_wvalid && m_wready) begin
      bit exp_last;
      exp_last = (w_beat == int'(aw_len_log[w_burst % 64]));
      chk(m_wdata == pat_data(w_n) && m_wstrb == pat_strb(w_n), "R9 data/strobe order",
          {28'd0, m_wstrb, m_wdata}, {28'd0, pat_strb(w_n), pat_data(w_n)});
      chk(m_wlast == exp_last, "R11 wlast", 64'(m_wlast), 64'(exp_last));
      if (exp_last) begin w_beat = 0; w_burst++; wl_done++; end
      else w_beat++;
      w_n++;
    end
    if (m_bvalid && m_bready) b_seen++;
    if (cmd_done) done_cnt++;
    if (cmd_err)  err_cnt++;
    if (aw_n - b_seen > peak) peak = aw_n - b_seen;
  end

  // Write response slave: one B per completed W burst, in order.
  initial forever begin
    @(posedge clk); #2;
    if (rst_n && wl_done > b_sent) begin
      m_bvalid = 1'b1;
      m_bresp  = (b_sent == err_idx) ? 2'b10 : 2'b00;
      @(negedge clk);
      while (!m_bready) @(negedge clk);
      @(posedge clk); #2;
      m_bvalid = 1'b0;
      m_bresp  = 2'b00;
      b_sent++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic send_cmd(input logic [31:0] addr, input int beats, input bit ll);
    @(posedge clk); #2;
    cmd_addr = addr; cmd_beats = SIZE_W'(beats); cmd_lowlat = ll; cmd_valid = 1'b1;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic push_words(input int n);
    @(posedge clk); #2;
    for (int i = 0; i < n; i++) begin
      wd_data = pat_data(push_idx); wd_strb = pat_strb(push_idx); wd_valid = 1'b1;
      @(negedge clk);
      while (!wd_ready) @(negedge clk);
      @(posedge clk); #2;
      push_idx++;
    end
    wd_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_resp(input int target, input string tag);
    int t = 0;
    while (done_cnt + err_cnt < target && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, tag, 64'(done_cnt + err_cnt), 64'(target));
    wait_cycles(3);
  endtask

  task automatic check_burst(input int idx, input logic [31:0] addr, input int len,
                             input string tag);
    chk(aw_addr_log[idx] == addr && aw_len_log[idx] == 8'(len), tag,
        {aw_addr_log[idx], 24'd0, aw_len_log[idx]}, {addr, 24'd0, 8'(len)});
  endtask

  task automatic t_reset();
    wait_cycles(1);
    chk(cmd_ready && wd_ready && m_bready && !m_awvalid && !m_wvalid && !cmd_done && !cmd_err,
        "R12 reset outputs",
        {58'd0, cmd_ready, wd_ready, m_bready, m_awvalid, m_wvalid, cmd_done | cmd_err},
        {58'd0, 6'b111000});
  endtask

  task automatic t_low_latency();
    int a0 = aw_n, w0 = w_n, d0 = done_cnt;
    send_cmd(32'h1000, 10, 1'b1);
    wait_cycles(10);
    chk(aw_n == a0 + 2 && !m_wvalid, "R4 address ahead of data",
        {32'(aw_n - a0), 31'd0, m_wvalid}, {32'd2, 32'd0});
    chk(peak == MAX_OUTST, "R8 outstanding limit reached not exceeded", 64'(peak), 64'(MAX_OUTST));
    fork
      push_words(10);
      begin
        int t = 0;
        @(negedge clk);
        while (!cmd_ready && t < 2000) begin @(negedge clk); t++; end
        chk(aw_n == a0 + 3 && w_n < w0 + 10, "R5 ready after last AW, data still flowing",
            {32'(aw_n - a0), 32'(w_n - w0)}, {32'd3, 32'd9});
      end
    join
    wait_resp(d0 + err_cnt + 1, "R6 low latency completion");
    chk(done_cnt == d0 + 1, "R6 single done for three bursts", 64'(done_cnt), 64'(d0 + 1));
    check_burst(a0,     32'h1000, 3, "R1 burst 0");
    check_burst(a0 + 1, 32'h1010, 3, "R1 burst 1");
    check_burst(a0 + 2, 32'h1020, 1, "R1 burst 2");
  endtask

  task automatic t_high_latency();
    int a0 = aw_n, d0 = done_cnt;
    send_cmd(32'h2000, 6, 1'b0);
    push_words(3);
    wait_cycles(10);
    chk(aw_n == a0 && !m_awvalid, "R3 held with 3 of 4 words", 64'(aw_n - a0), 64'd0);
    push_words(1);
    wait_cycles(15);
    chk(aw_n == a0 + 1, "R3 first burst issued when data complete", 64'(aw_n - a0), 64'd1);
    chk(!m_awvalid && !cmd_ready, "R3 second burst rechecked and held",
        {62'd0, m_awvalid, cmd_ready}, 64'd0);
    push_words(2);
    wait_resp(done_cnt + err_cnt + 1, "R6 high latency completion");
    chk(done_cnt == d0 + 1, "R6 high latency done", 64'(done_cnt), 64'(d0 + 1));
    check_burst(a0,     32'h2000, 3, "R1 hl burst 0");
    check_burst(a0 + 1, 32'h2010, 1, "R1 hl burst 1");
  endtask

  task automatic t_page_and_prefill();
    int a0 = aw_n;
    push_words(5);
    aw_rdy_en = 1'b0;
    send_cmd(32'h3FF8, 5, 1'b1);
    wait_cycles(8);
    chk(m_awvalid && aw_n == a0, "R13 address held while not ready",
        {31'd0, m_awvalid, 32'(aw_n - a0)}, {31'd0, 1'b1, 32'd0});
    aw_rdy_en = 1'b1;
    wait_resp(done_cnt + err_cnt + 1, "R9 data-first completion");
    check_burst(a0,     32'h3FF8, 1, "R2 burst before page end");
    check_burst(a0 + 1, 32'h4000, 2, "R2 burst after page end");
  endtask

  task automatic t_error();
    int d0 = done_cnt, e0 = err_cnt, a0 = aw_n;
    err_idx = b_sent + 1;
    w_stall = 1'b1;
    push_words(9);
    send_cmd(32'h5000, 9, 1'b1);
    wait_resp(d0 + e0 + 1, "R7 error completion");
    chk(err_cnt == e0 + 1 && done_cnt == d0, "R7 error replaces done",
        {32'(err_cnt - e0), 32'(done_cnt - d0)}, {32'd1, 32'd0});
    check_burst(a0 + 2, 32'h5020, 0, "R1 single-beat tail");
    w_stall = 1'b0;
    err_idx = -1;
    push_words(1);
    send_cmd(32'h6000, 1, 1'b0);
    wait_resp(d0 + e0 + 2, "R7 next request");
    chk(done_cnt == d0 + 1 && err_cnt == e0 + 1, "R7 error state cleared for next request",
        {32'(done_cnt - d0), 32'(err_cnt - e0)}, {32'd1, 32'd1});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_low_latency();
    t_high_latency();
    t_page_and_prefill();
    t_error();
    chk(peak <= MAX_OUTST, "R8 outstanding bound over run", 64'(peak), 64'(MAX_OUTST));
    chk(w_n == push_idx, "R9 every pushed word sent", 64'(w_n), 64'(push_idx));
    finish_run();
  end

endmodule